// File: doc/BRIEF.md
# Register Rename Stage with Free-Register Pool

This block sits in the front end of an out-of-order core. It translates each incoming instruction from architectural register numbers to physical register numbers. The physical register file is larger than the architectural one. Each source operand is replaced by the physical register that holds the newest value of that architectural register. Each instruction that produces a result is given a physical register that nothing currently references. Because every result gets its own new register, write-after-write and write-after-read conflicts disappear, and only true data dependences remain.

The stage handles one instruction per cycle with a valid/ready handshake, and its outputs are combinational. When an instruction writes a register, the stage also reports the physical register the destination was mapped to before. Retirement logic later hands that register back through a release port. Released registers join the tail of a first-in first-out pool of free physical registers.

Top module: `rn_rename_stage`

## Requirements
- R1: After reset, architectural register i maps to physical register i, for i from 0 to LOG_REGS-1. The pool holds physical registers LOG_REGS to PHYS_REGS-1 in ascending order, with LOG_REGS at the head.
- R2: Each accepted source (`in_src_a`, `in_src_b`) is output as the physical register written by the most recent earlier accepted instruction with that architectural destination, or as its reset mapping if there is none.
- R3: An accepted instruction with `in_dst_en`=1 receives the physical register at the head of the pool on `out_dst`. That register is then removed from the pool and becomes the destination's new mapping. Two writes to the same architectural register therefore get different physical registers.
- R4: For an accepted instruction with `in_dst_en`=1, `out_prev` carries the physical register its destination mapped to just before this instruction.
- R5: A source that names the instruction's own destination is translated through the mapping that held before this instruction, not through its newly allocated register.
- R6: An accepted instruction with `in_dst_en`=0 takes nothing from the pool and leaves every mapping unchanged.
- R7: `in_ready` is 0 exactly when `in_dst_en`=1 and the pool is empty. An instruction without a destination is accepted even when the pool is empty.
- R8: A register given back with `rel_valid`=1 joins the tail of the pool at the next clock edge. It cannot be allocated in the cycle it is returned, and it is allocated only after every register that was ahead of it.
- R9: `out_valid` equals `in_valid && in_ready`. A cycle with `in_valid`=0 changes no mapping and takes nothing from the pool.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The stage can accept the offered instruction |
| in_src_a | input | LW | First source, architectural number |
| in_src_b | input | LW | Second source, architectural number |
| in_dst_en | input | 1 | The instruction writes a register |
| in_dst | input | LW | Destination, architectural number |
| out_valid | output | 1 | The outputs below describe an accepted instruction |
| out_src_a | output | PW | First source, physical number |
| out_src_b | output | PW | Second source, physical number |
| out_dst | output | PW | Newly allocated physical destination (0 when no destination) |
| out_prev | output | PW | Physical register the destination mapped to before (0 when no destination) |
| rel_valid | input | 1 | A physical register is being returned |
| rel_phys | input | PW | Physical register being returned |

LW is the bit width of an architectural register number, 3 by default. PW is the bit width of a physical register number, 5 by default.

## Verification
A corrupted map entry shows up on the first later instruction that reads that architectural register as a source, or that writes it and so reports it on `out_prev`. That can happen many cycles after the fault. A corrupted pool pointer or count shows up at the next allocation as a wrong value on `out_dst`, or as `in_ready` falling too early or too late at exhaustion. The bench therefore follows every accepted instruction with a model of the map and the pool, so that a delayed fault is still traced to the cycle where it appears. It also drives the pool to empty so that the stall boundary and the reuse of returned registers are reached.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
    localparam int RN_LOG_DEFAULT  = 8;
    localparam int RN_PHYS_DEFAULT = 32;

    // bit width needed to index n items, never less than one
    function automatic int rn_idx_bits(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list #(
    parameter int PHYS_REGS = rn_pkg::RN_PHYS_DEFAULT,
    parameter int LOG_REGS  = rn_pkg::RN_LOG_DEFAULT
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       pop,
    input  logic                                       push,
    input  logic [rn_pkg::rn_idx_bits(PHYS_REGS)-1:0]  push_idx,
    output logic [rn_pkg::rn_idx_bits(PHYS_REGS)-1:0]  head_idx,
    output logic                                       empty
);
    localparam int PW = rn_pkg::rn_idx_bits(PHYS_REGS);
    localparam int CW = $clog2(PHYS_REGS + 1);
    localparam int INIT_CNT = PHYS_REGS - LOG_REGS;

    typedef struct packed {
        logic [PHYS_REGS-1:0][PW-1:0] slot;
        logic [PW-1:0]                rd;
        logic [PW-1:0]                wr;
        logic [CW-1:0]                cnt;
    } pool_t;

    pool_t pool_d, pool_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(PHYS_REGS - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic pool_t pool_init();
        pool_t s;
        for (int i = 0; i < PHYS_REGS; i++) begin
            s.slot[i] = (i < INIT_CNT) ? PW'(i + LOG_REGS) : '0;
        end
        s.rd  = '0;
        s.wr  = PW'(INIT_CNT % PHYS_REGS);
        s.cnt = CW'(INIT_CNT);
        return s;
    endfunction

    assign head_idx = pool_q.slot[pool_q.rd];
    assign empty    = (pool_q.cnt == '0);

    always_comb begin
        pool_d = pool_q;
        if (pop) begin
            pool_d.rd = bump(pool_q.rd);
        end
        if (push) begin
            pool_d.slot[pool_q.wr] = push_idx;
            pool_d.wr              = bump(pool_q.wr);
        end
        pool_d.cnt = pool_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_q <= pool_init();
        end else begin
            pool_q <= pool_d;
        end
    end

    // R7: nothing is taken from an empty pool
    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (pool_q.cnt != '0));

    // R8: the pool never holds more entries than there are physical registers
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pool_q.cnt <= CW'(PHYS_REGS));

    // R6: without a pop or a push the occupancy holds
    a_r6_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && !push) |=> $stable(pool_q.cnt));
endmodule

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
module rn_map_table #(
    parameter int PHYS_REGS = rn_pkg::RN_PHYS_DEFAULT,
    parameter int LOG_REGS  = rn_pkg::RN_LOG_DEFAULT
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [rn_pkg::rn_idx_bits(LOG_REGS)-1:0]   rd_a_idx,
    input  logic [rn_pkg::rn_idx_bits(LOG_REGS)-1:0]   rd_b_idx,
    input  logic [rn_pkg::rn_idx_bits(LOG_REGS)-1:0]   rd_d_idx,
    output logic [rn_pkg::rn_idx_bits(PHYS_REGS)-1:0]  rd_a_phys,
    output logic [rn_pkg::rn_idx_bits(PHYS_REGS)-1:0]  rd_b_phys,
    output logic [rn_pkg::rn_idx_bits(PHYS_REGS)-1:0]  rd_d_phys,
    input  logic                                       wr_en,
    input  logic [rn_pkg::rn_idx_bits(LOG_REGS)-1:0]   wr_idx,
    input  logic [rn_pkg::rn_idx_bits(PHYS_REGS)-1:0]  wr_phys
);
    localparam int PW = rn_pkg::rn_idx_bits(PHYS_REGS);

    typedef struct packed {
        logic [LOG_REGS-1:0][PW-1:0] ent;
    } map_t;

    map_t map_d, map_q;

    // reads see the registered map: a same-cycle write is not visible to
    // its own instruction, which gives the old mapping to a source that
    // names its own destination
    assign rd_a_phys = map_q.ent[rd_a_idx];
    assign rd_b_phys = map_q.ent[rd_b_idx];
    assign rd_d_phys = map_q.ent[rd_d_idx];

    always_comb begin
        map_d = map_q;
        if (wr_en) begin
            map_d.ent[wr_idx] = wr_phys;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LOG_REGS; i++) begin
                map_q.ent[i] <= PW'(i);
            end
        end else begin
            map_q <= map_d;
        end
    end

    logic fresh_clash;
    always_comb begin
        fresh_clash = 1'b0;
        for (int i = 0; i < LOG_REGS; i++) begin
            if (map_q.ent[i] == wr_phys) fresh_clash = 1'b1;
        end
    end

    // R3: a newly allocated register is referenced by no current mapping
    a_r3_fresh_dest: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !fresh_clash);

    // R2: after a write the entry holds the allocated register
    a_r2_map_update: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (map_q.ent[$past(wr_idx)] == $past(wr_phys)));
endmodule

// File: rtl/rn_rename_stage.sv
`timescale 1ns/1ps
module rn_rename_stage #(
    parameter int PHYS_REGS = rn_pkg::RN_PHYS_DEFAULT,
    parameter int LOG_REGS  = rn_pkg::RN_LOG_DEFAULT,
    localparam int LW = rn_pkg::rn_idx_bits(LOG_REGS),
    localparam int PW = rn_pkg::rn_idx_bits(PHYS_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [LW-1:0] in_src_a,
    input  logic [LW-1:0] in_src_b,
    input  logic          in_dst_en,
    input  logic [LW-1:0] in_dst,
    output logic          out_valid,
    output logic [PW-1:0] out_src_a,
    output logic [PW-1:0] out_src_b,
    output logic [PW-1:0] out_dst,
    output logic [PW-1:0] out_prev,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_phys
);
    logic          pool_empty;
    logic [PW-1:0] pool_head;
    logic [PW-1:0] old_dst_phys;
    logic          accept;
    logic          alloc;

    assign in_ready  = !(in_dst_en && pool_empty);
    assign accept    = in_valid && in_ready;
    assign alloc     = accept && in_dst_en;
    assign out_valid = accept;
    assign out_dst   = in_dst_en ? pool_head    : '0;
    assign out_prev  = in_dst_en ? old_dst_phys : '0;

    rn_free_list #(
        .PHYS_REGS (PHYS_REGS),
        .LOG_REGS  (LOG_REGS)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (rel_valid),
        .push_idx (rel_phys),
        .head_idx (pool_head),
        .empty    (pool_empty)
    );

    rn_map_table #(
        .PHYS_REGS (PHYS_REGS),
        .LOG_REGS  (LOG_REGS)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (in_src_a),
        .rd_b_idx  (in_src_b),
        .rd_d_idx  (in_dst),
        .rd_a_phys (out_src_a),
        .rd_b_phys (out_src_b),
        .rd_d_phys (old_dst_phys),
        .wr_en     (alloc),
        .wr_idx    (in_dst),
        .wr_phys   (pool_head)
    );

    // R4: the reported old mapping is never the register handed out now
    a_r4_prev_differs: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (out_prev != out_dst));

    // R9: an accepted instruction is always an offered one
    a_r9_valid_offered: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid);
endmodule

// File: tb/sim_rn_rename_stage.sv
`timescale 1ns/1ps
module sim_rn_rename_stage;
    localparam int L  = 8;
    localparam int P  = 32;
    localparam int LW = 3;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [LW-1:0] in_src_a = '0;
    logic [LW-1:0] in_src_b = '0;
    logic          in_dst_en = 1'b0;
    logic [LW-1:0] in_dst = '0;
    logic          out_valid;
    logic [PW-1:0] out_src_a, out_src_b, out_dst, out_prev;
    logic          rel_valid = 1'b0;
    logic [PW-1:0] rel_phys = '0;

    int checks = 0;
    int failures = 0;
    int map_m [L];
    int pool_m [$];
    int last_prev;

    always #10 clk = ~clk;

    rn_rename_stage #(.PHYS_REGS(P), .LOG_REGS(L)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst_en(in_dst_en),
        .in_dst(in_dst), .out_valid(out_valid), .out_src_a(out_src_a),
        .out_src_b(out_src_b), .out_dst(out_dst), .out_prev(out_prev),
        .rel_valid(rel_valid), .rel_phys(rel_phys)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; rel_valid = 1'b0; in_dst_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < L; i++) map_m[i] = i;
        pool_m.delete();
        for (int i = L; i < P; i++) pool_m.push_back(i);
    endtask

    // one cycle: drive at the falling edge, check mid-low, model the edge
    task automatic step(input string tag, input bit v, input int a, input int b,
                        input bit de, input int d, input bit fv, input int fp);
        bit rdy;
        bit fire;
        @(negedge clk);
        in_valid = v; in_src_a = LW'(a); in_src_b = LW'(b);
        in_dst_en = de; in_dst = LW'(d); rel_valid = fv; rel_phys = PW'(fp);
        #5;
        rdy  = !(de && pool_m.size() == 0);
        fire = v && rdy;
        chk({tag, "/R7"}, "in_ready", int'(in_ready), int'(rdy));
        chk({tag, "/R9"}, "out_valid", int'(out_valid), int'(fire));
        if (fire) begin
            chk({tag, "/R2"}, "out_src_a", int'(out_src_a), map_m[a]);
            chk({tag, "/R2"}, "out_src_b", int'(out_src_b), map_m[b]);
            if (de) begin
                chk({tag, "/R3"}, "out_dst", int'(out_dst), pool_m[0]);
                chk({tag, "/R4"}, "out_prev", int'(out_prev), map_m[d]);
                last_prev = map_m[d];
                map_m[d] = pool_m.pop_front();
            end
        end
        if (fv) pool_m.push_back(fp);
    endtask

    task automatic t_reset_state();
        do_reset();
        // R1: identity mapping read through no-destination instructions
        for (int i = 0; i < L; i++) begin
            step("R1", 1, i, L - 1 - i, 0, 0, 0, 0);
            chk("R1", "identity map", int'(out_src_a), i);
        end
        step("R1", 1, 0, 0, 1, 6, 0, 0);
        chk("R1", "first allocation", int'(out_dst), L);
        chk("R1", "first old mapping", int'(out_prev), 6);
    endtask

    task automatic t_chain();
        do_reset();
        step("R2", 1, 1, 2, 1, 1, 0, 0);
        step("R2", 1, 1, 1, 1, 1, 0, 0);
        chk("R3", "second write to r1 differs", int'(out_dst), 9);
        chk("R4", "old mapping of r1", int'(out_prev), 8);
        step("R2", 1, 1, 3, 1, 3, 0, 0);
        chk("R2", "r1 reads newest producer", int'(out_src_a), 9);
        for (int i = 0; i < 10; i++) step("R2", 1, (i * 3) % L, (i * 5 + 1) % L, 1, (i * 7) % L, 0, 0);
    endtask

    task automatic t_self_source();
        do_reset();
        step("R5", 1, 4, 0, 1, 4, 0, 0);
        step("R5", 1, 4, 4, 1, 4, 0, 0);
        chk("R5", "own dest source gets old map", int'(out_src_a), 8);
        chk("R5", "own dest new reg", int'(out_dst), 9);
    endtask

    task automatic t_no_dest();
        do_reset();
        step("R6", 1, 2, 3, 1, 2, 0, 0);
        step("R6", 1, 5, 2, 0, 2, 0, 0);
        step("R6", 1, 6, 7, 0, 7, 0, 0);
        step("R6", 1, 2, 7, 1, 0, 0, 0);
        chk("R6", "map kept after store", int'(out_src_a), 8);
        chk("R6", "r7 untouched", int'(out_src_b), 7);
        chk("R6", "pool not consumed", int'(out_dst), 9);
    endtask

    task automatic t_idle();
        do_reset();
        step("R9", 0, 0, 0, 1, 3, 0, 0);
        step("R9", 0, 0, 0, 1, 3, 0, 0);
        step("R9", 1, 3, 3, 1, 3, 0, 0);
        chk("R9", "idle kept map", int'(out_src_a), 3);
        chk("R9", "idle kept pool", int'(out_dst), 8);
    endtask

    task automatic t_exhaust_release();
        int rel;
        do_reset();
        step("R8", 1, 0, 1, 1, 0, 0, 0);
        rel = last_prev;
        for (int i = 1; i < P - L; i++) step("R8", 1, i % L, (i + 2) % L, 1, i % L, 0, 0);
        step("R7", 1, 1, 2, 0, 0, 0, 0);
        chk("R7", "no-dest accepted when empty", int'(in_ready), 1);
        step("R7", 1, 1, 2, 1, 5, 1, rel);
        chk("R7", "stall when empty", int'(in_ready), 0);
        chk("R8", "returned reg not usable same cycle", int'(out_valid), 0);
        step("R8", 1, 1, 2, 1, 5, 0, 0);
        chk("R8", "returned reg allocated next cycle", int'(out_dst), rel);
        step("R7", 1, 1, 2, 1, 6, 0, 0);
        chk("R7", "empty again", int'(in_ready), 0);
    endtask

    task automatic t_fifo_order();
        do_reset();
        step("R8", 1, 0, 0, 1, 3, 1, 3);
        for (int i = 0; i < P - L - 1; i++) step("R8", 1, 1, 2, 1, 2, 0, 0);
        step("R8", 1, 0, 0, 1, 4, 0, 0);
        chk("R8", "returned reg comes after older entries", int'(out_dst), 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_chain();
        t_self_source();
        t_no_dest();
        t_idle();
        t_exhaust_release();
        t_fifo_order();
        @(negedge clk);
        in_valid = 1'b0; rel_valid = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule